// File: doc/BRIEF.md
# DMA Descriptor Error Checker and Logger

This block sits beside a DMA transfer engine and screens every transfer descriptor before its channel is allowed to start. It checks that source and destination addresses fit the chosen access size, that the signed per-access offsets are whole multiples of that size, and that the byte and iteration counts are sane. When a major loop finishes with descriptor chaining enabled, it checks that the next-descriptor address sits on a 32-byte boundary. It also takes bus-error strobes from the read and write sides and a cancel strobe from the engine.

Every detected problem goes into a single-entry log. The log keeps the error bits of the latest event and the channel that raised it. It is presented as one 32-bit status word with a valid flag, and a one-cycle pulse marks each new entry. An optional policy turns any error into a sticky halt request. While the halt is active, new descriptor checks (channel start requests) are ignored, but errors from transfers already in flight are still recorded. Software empties the log with a clear strobe and releases the halt with a separate strobe.

Only the low address and offset bits take part in the alignment checks, so the ports carry just those bits.

Top module: `dma_err_logger`

## Requirements
- R1: After synchronous reset the status word is zero, and the valid flag, error pulse and halt request are all low.
- R2: On a descriptor check (`chk_start`), a source address that is not a multiple of the source access size sets status bit 7. A destination address that is not a multiple of the destination access size sets bit 5. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The status word changes one cycle after the strobe.
- R3: A size code of 4 to 7 sets the address error bit for that side (bit 7 for source, bit 5 for destination) and does not set that side's offset error bit.
- R4: A source offset that is not a multiple of the source size sets bit 6. A destination offset that is not a multiple of the destination size sets bit 4. Offsets are two's complement, so negative values are checked the same way.
- R5: A descriptor check with a zero minor byte count, or with a current iteration count different from the beginning count, sets bit 3.
- R6: On `major_done` with `sg_enable` high, a next-descriptor address whose five low bits are not all zero sets bit 2. With `sg_enable` low, the address is not checked.
- R7: `rd_bus_err` sets bit 1, `wr_bus_err` sets bit 0 and `xfer_cancel` sets bit 8.
- R8: Bits 29:24 hold the channel number of the logged event. Bit 31 and `err_valid` are high exactly when any of bits 8:0 is set.
- R9: A new event replaces all error bits and the channel number, with no accumulation. A descriptor check that finds no fault leaves the log unchanged.
- R10: `err_pulse` is high for one cycle, in the cycle the status word takes a new event, and is low otherwise.
- R11: With `halt_on_err` high, any logged event sets `halt_req`. The halt stays set until `halt_clr`. With the policy low, an event does not raise it.
- R12: While `halt_req` is high, `chk_start` is ignored: nothing is logged and no pulse is produced. Bus-error, cancel and chaining checks are still logged.
- R13: `log_clr` zeroes the error bits, the channel and valid in one cycle and leaves `halt_req` unchanged. If an event arrives in the same cycle, the event is logged instead.
- R14: Faults from several sources in the same cycle are merged into one entry holding all of their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_start | input | 1 | Descriptor check strobe (channel start request) |
| ev_chan | input | CHAN_W | Channel number of the current event |
| src_addr_lo | input | 3 | Low bits of the source address |
| dst_addr_lo | input | 3 | Low bits of the destination address |
| src_off_lo | input | 3 | Low bits of the signed source offset |
| dst_off_lo | input | 3 | Low bits of the signed destination offset |
| src_size | input | 3 | Source access size code |
| dst_size | input | 3 | Destination access size code |
| minor_bytes | input | NB_W | Minor loop byte count |
| cur_iter | input | IT_W | Current major iteration count |
| beg_iter | input | IT_W | Beginning major iteration count |
| major_done | input | 1 | Major loop completion strobe |
| sg_enable | input | 1 | Descriptor chaining enabled for the channel |
| sg_addr_lo | input | SG_ALIGN_LOG2 | Low bits of the next-descriptor address |
| rd_bus_err | input | 1 | Source read bus error strobe |
| wr_bus_err | input | 1 | Destination write bus error strobe |
| xfer_cancel | input | 1 | Transfer cancelled strobe |
| halt_on_err | input | 1 | Policy: halt on any error |
| halt_clr | input | 1 | Release the halt request |
| log_clr | input | 1 | Clear the error log |
| err_status | output | 32 | Error status word |
| err_valid | output | 1 | Log holds an uncleared error |
| err_pulse | output | 1 | One-cycle pulse for a new logged event |
| halt_req | output | 1 | Halt request to the engine |

## Verification
The hardest state to reach is the one where a halt is active, the log has been emptied, and a faulty descriptor arrives. Only in that state does an ignored start request differ from a logged one, because a stale entry would hide whether the start was ignored. The stimulus reaches it in a fixed order: enable the policy, raise an error to set the halt, clear the log while the halt stays, then present a misaligned descriptor. The bench then shows that a bus error is still logged and that the same descriptor is logged once the halt is released. The same-cycle collisions, clear against a new event and several fault sources at once, are driven as single-cycle combined strobes.

// File: rtl/dmachk_pkg.sv
package dmachk_pkg;

    // Low address/offset bits needed to judge alignment to the widest access (8 bytes)
    localparam int SZ_LO_W      = 3;
    localparam int SZ_CODE_W    = 3;
    localparam int STAT_W       = 32;
    localparam int CHAN_LSB     = 24;
    localparam int CHAN_FIELD_W = 6;
    localparam int VALID_BIT    = 31;

    // Error bits, MSB first, so that the packed position equals the status bit
    typedef struct packed {
        logic cancel;    // 8
        logic src_addr;  // 7
        logic src_off;   // 6
        logic dst_addr;  // 5
        logic dst_off;   // 4
        logic iter;      // 3
        logic sg;        // 2
        logic src_bus;   // 1
        logic dst_bus;   // 0
    } err_bits_t;

    localparam int ERR_W = $bits(err_bits_t);

    typedef struct packed {
        logic [SZ_LO_W-1:0]   src_addr;
        logic [SZ_LO_W-1:0]   dst_addr;
        logic [SZ_LO_W-1:0]   src_off;
        logic [SZ_LO_W-1:0]   dst_off;
        logic [SZ_CODE_W-1:0] src_sz;
        logic [SZ_CODE_W-1:0] dst_sz;
    } desc_lo_t;

    function automatic logic size_code_ok(input logic [SZ_CODE_W-1:0] code);
        return code <= SZ_CODE_W'(SZ_LO_W);
    endfunction

    // Mask of low bits that must be zero for the given access size
    function automatic logic [SZ_LO_W-1:0] size_mask(input logic [SZ_CODE_W-1:0] code);
        logic [SZ_LO_W-1:0] m;
        m = '0;
        for (int i = 0; i < SZ_LO_W; i++) begin
            if (code > SZ_CODE_W'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/size_chk.sv
module size_chk
    import dmachk_pkg::*;
(
    input  logic [SZ_LO_W-1:0]   addr_lo,
    input  logic [SZ_LO_W-1:0]   off_lo,
    input  logic [SZ_CODE_W-1:0] code,
    output logic                 addr_err,
    output logic                 off_err
);
    logic               code_ok;
    logic [SZ_LO_W-1:0] mask;

    always_comb begin
        code_ok  = size_code_ok(code);
        mask     = size_mask(code);
        addr_err = !code_ok || ((addr_lo & mask) != '0);
        off_err  = code_ok && ((off_lo & mask) != '0);
    end
endmodule

// File: rtl/desc_checker.sv
module desc_checker
    import dmachk_pkg::*;
#(
    parameter int NB_W = 30,
    parameter int IT_W = 15
) (
    input  desc_lo_t         desc,
    input  logic [NB_W-1:0]  minor_bytes,
    input  logic [IT_W-1:0]  cur_iter,
    input  logic [IT_W-1:0]  beg_iter,
    output err_bits_t        err
);
    localparam int N_SIDE = 2;  // 0 = source, 1 = destination

    logic [N_SIDE-1:0][SZ_LO_W-1:0]   a_lo;
    logic [N_SIDE-1:0][SZ_LO_W-1:0]   o_lo;
    logic [N_SIDE-1:0][SZ_CODE_W-1:0] sz;
    logic [N_SIDE-1:0]                a_err;
    logic [N_SIDE-1:0]                o_err;

    assign a_lo[0] = desc.src_addr;
    assign a_lo[1] = desc.dst_addr;
    assign o_lo[0] = desc.src_off;
    assign o_lo[1] = desc.dst_off;
    assign sz[0]   = desc.src_sz;
    assign sz[1]   = desc.dst_sz;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        size_chk u_size (
            .addr_lo (a_lo[s]),
            .off_lo  (o_lo[s]),
            .code    (sz[s]),
            .addr_err(a_err[s]),
            .off_err (o_err[s])
        );
    end

    always_comb begin
        err          = '0;
        err.src_addr = a_err[0];
        err.src_off  = o_err[0];
        err.dst_addr = a_err[1];
        err.dst_off  = o_err[1];
        err.iter     = (minor_bytes == '0) || (cur_iter != beg_iter);
    end
endmodule

// File: rtl/err_log.sv
module err_log
    import dmachk_pkg::*;
#(
    parameter int CHAN_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  err_bits_t         ev_err,
    input  logic [CHAN_W-1:0] ev_chan,
    input  logic              clr,
    output err_bits_t         bits_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              pulse_q
);
    logic ev_any;
    assign ev_any = |ev_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q  <= '0;
            chan_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= ev_any;
            if (ev_any) begin
                bits_q <= ev_err;
                chan_q <= ev_chan;
            end else if (clr) begin
                bits_q <= '0;
                chan_q <= '0;
            end
        end
    end
endmodule

// File: rtl/halt_ctl.sv
module halt_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ev_any,
    input  logic policy,
    input  logic clr,
    output logic halt_q
);
    always_ff @(posedge clk) begin
        if (rst)                   halt_q <= 1'b0;
        else if (ev_any && policy) halt_q <= 1'b1;
        else if (clr)              halt_q <= 1'b0;
    end
endmodule

// File: rtl/dma_err_logger.sv
module dma_err_logger
    import dmachk_pkg::*;
#(
    parameter int CHAN_W        = 6,
    parameter int NB_W          = 30,
    parameter int IT_W          = 15,
    parameter int SG_ALIGN_LOG2 = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     chk_start,
    input  logic [CHAN_W-1:0]        ev_chan,
    input  logic [SZ_LO_W-1:0]       src_addr_lo,
    input  logic [SZ_LO_W-1:0]       dst_addr_lo,
    input  logic [SZ_LO_W-1:0]       src_off_lo,
    input  logic [SZ_LO_W-1:0]       dst_off_lo,
    input  logic [SZ_CODE_W-1:0]     src_size,
    input  logic [SZ_CODE_W-1:0]     dst_size,
    input  logic [NB_W-1:0]          minor_bytes,
    input  logic [IT_W-1:0]          cur_iter,
    input  logic [IT_W-1:0]          beg_iter,
    input  logic                     major_done,
    input  logic                     sg_enable,
    input  logic [SG_ALIGN_LOG2-1:0] sg_addr_lo,
    input  logic                     rd_bus_err,
    input  logic                     wr_bus_err,
    input  logic                     xfer_cancel,
    input  logic                     halt_on_err,
    input  logic                     halt_clr,
    input  logic                     log_clr,
    output logic [STAT_W-1:0]        err_status,
    output logic                     err_valid,
    output logic                     err_pulse,
    output logic                     halt_req
);
    localparam int CH_USE = (CHAN_W < CHAN_FIELD_W) ? CHAN_W : CHAN_FIELD_W;

    desc_lo_t          desc;
    err_bits_t         desc_err;
    err_bits_t         ev_err;
    err_bits_t         bits_q;
    logic [CHAN_W-1:0] chan_q;
    logic              desc_take;

    assign desc = '{src_addr: src_addr_lo, dst_addr: dst_addr_lo,
                    src_off:  src_off_lo,  dst_off:  dst_off_lo,
                    src_sz:   src_size,    dst_sz:   dst_size};

    // Start requests are refused while halted; in-flight reports are not
    assign desc_take = chk_start && !halt_req;

    desc_checker #(.NB_W(NB_W), .IT_W(IT_W)) u_desc (
        .desc       (desc),
        .minor_bytes(minor_bytes),
        .cur_iter   (cur_iter),
        .beg_iter   (beg_iter),
        .err        (desc_err)
    );

    always_comb begin
        ev_err         = desc_take ? desc_err : '0;
        ev_err.sg      = major_done && sg_enable && (sg_addr_lo != '0);
        ev_err.src_bus = rd_bus_err;
        ev_err.dst_bus = wr_bus_err;
        ev_err.cancel  = xfer_cancel;
    end

    err_log #(.CHAN_W(CHAN_W)) u_log (
        .clk    (clk),
        .rst    (rst),
        .ev_err (ev_err),
        .ev_chan(ev_chan),
        .clr    (log_clr),
        .bits_q (bits_q),
        .chan_q (chan_q),
        .pulse_q(err_pulse)
    );

    halt_ctl u_halt (
        .clk   (clk),
        .rst   (rst),
        .ev_any(|ev_err),
        .policy(halt_on_err),
        .clr   (halt_clr),
        .halt_q(halt_req)
    );

    always_comb begin
        err_status                        = '0;
        err_status[ERR_W-1:0]             = bits_q;
        err_status[CHAN_LSB +: CH_USE]    = chan_q[CH_USE-1:0];
        err_status[VALID_BIT]             = |bits_q;
        err_valid                         = |bits_q;
    end
endmodule

// File: rtl/dma_err_logger_chk.sv
module dma_err_logger_chk (
    input logic        clk,
    input logic        rst,
    input logic        chk_start,
    input logic        major_done,
    input logic        rd_bus_err,
    input logic        wr_bus_err,
    input logic        xfer_cancel,
    input logic        halt_on_err,
    input logic        halt_clr,
    input logic        log_clr,
    input logic [31:0] err_status,
    input logic        err_valid,
    input logic        err_pulse,
    input logic        halt_req
);
    logic no_report;
    assign no_report = !major_done && !rd_bus_err && !wr_bus_err && !xfer_cancel;

    a_r10_pulse_has_entry: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_valid);

    a_r8_valid_consistent: assert property (@(posedge clk) disable iff (rst)
        (err_valid == (err_status[8:0] != 9'd0)) && (err_status[31] == err_valid));

    a_r7_read_error_logged: assert property (@(posedge clk) disable iff (rst)
        rd_bus_err |=> (err_status[1] && err_pulse));

    a_r7_cancel_logged: assert property (@(posedge clk) disable iff (rst)
        xfer_cancel |=> err_status[8]);

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !halt_clr) |=> halt_req);

    a_r11_no_policy_no_halt: assert property (@(posedge clk) disable iff (rst)
        (!halt_req && !halt_on_err) |=> !halt_req);

    a_r13_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (log_clr && !chk_start && no_report) |=> (err_status == 32'd0));

    a_r12_halt_blocks_start: assert property (@(posedge clk) disable iff (rst)
        (halt_req && chk_start && no_report) |=> !err_pulse);
endmodule

bind dma_err_logger dma_err_logger_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chk_start  (chk_start),
    .major_done (major_done),
    .rd_bus_err (rd_bus_err),
    .wr_bus_err (wr_bus_err),
    .xfer_cancel(xfer_cancel),
    .halt_on_err(halt_on_err),
    .halt_clr   (halt_clr),
    .log_clr    (log_clr),
    .err_status (err_status),
    .err_valid  (err_valid),
    .err_pulse  (err_pulse),
    .halt_req   (halt_req)
);

// File: tb/test_dma_err_logger.sv
module test_dma_err_logger;
    logic        clk = 1'b0;
    logic        rst;
    logic        chk_start;
    logic [5:0]  ev_chan;
    logic [2:0]  src_addr_lo, dst_addr_lo, src_off_lo, dst_off_lo;
    logic [2:0]  src_size, dst_size;
    logic [29:0] minor_bytes;
    logic [14:0] cur_iter, beg_iter;
    logic        major_done, sg_enable;
    logic [4:0]  sg_addr_lo;
    logic        rd_bus_err, wr_bus_err, xfer_cancel;
    logic        halt_on_err, halt_clr, log_clr;
    logic [31:0] err_status;
    logic        err_valid, err_pulse, halt_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_err_logger i_dma_err_logger (
        .clk(clk), .rst(rst), .chk_start(chk_start), .ev_chan(ev_chan),
        .src_addr_lo(src_addr_lo), .dst_addr_lo(dst_addr_lo),
        .src_off_lo(src_off_lo), .dst_off_lo(dst_off_lo),
        .src_size(src_size), .dst_size(dst_size), .minor_bytes(minor_bytes),
        .cur_iter(cur_iter), .beg_iter(beg_iter), .major_done(major_done),
        .sg_enable(sg_enable), .sg_addr_lo(sg_addr_lo), .rd_bus_err(rd_bus_err),
        .wr_bus_err(wr_bus_err), .xfer_cancel(xfer_cancel), .halt_on_err(halt_on_err),
        .halt_clr(halt_clr), .log_clr(log_clr), .err_status(err_status),
        .err_valid(err_valid), .err_pulse(err_pulse), .halt_req(halt_req)
    );

    function automatic logic [31:0] stat(input int ch, input logic [8:0] bits);
        return (bits != 9'd0) ? (32'h8000_0000 | (32'(ch) << 24) | 32'(bits)) : 32'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic good_desc();
        src_addr_lo = 3'd0; dst_addr_lo = 3'd0; src_off_lo = 3'd4; dst_off_lo = 3'd4;
        src_size = 3'd2; dst_size = 3'd2; minor_bytes = 30'd16;
        cur_iter = 15'd10; beg_iter = 15'd10;
    endtask

    // Assert the chosen strobes for one cycle; outputs are sampled on return
    task automatic pulse(input int ch, input bit st, input bit md, input bit rd,
                         input bit wr, input bit cx, input bit lc, input bit hc);
        ev_chan = 6'(ch);
        chk_start = st; major_done = md; rd_bus_err = rd; wr_bus_err = wr;
        xfer_cancel = cx; log_clr = lc; halt_clr = hc;
        @(negedge clk);
        chk_start = 0; major_done = 0; rd_bus_err = 0; wr_bus_err = 0;
        xfer_cancel = 0; log_clr = 0; halt_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 status", err_status, 32'd0);
        check("R1 valid", 32'(err_valid), 32'd0);
        check("R1 pulse", 32'(err_pulse), 32'd0);
        check("R1 halt", 32'(halt_req), 32'd0);
        good_desc();
        pulse(3, 1, 0, 0, 0, 0, 0, 0);
        check("R9 clean descriptor leaves log empty", err_status, 32'd0);
        check("R10 no pulse on clean descriptor", 32'(err_pulse), 32'd0);
    endtask

    task automatic t_addr();
        good_desc(); src_addr_lo = 3'd2;
        pulse(5, 1, 0, 0, 0, 0, 0, 0);
        check("R2 source misaligned", err_status, stat(5, 9'h080));
        check("R10 pulse on event", 32'(err_pulse), 32'd1);
        check("R8 valid", 32'(err_valid), 32'd1);
        @(negedge clk);
        check("R10 pulse is one cycle", 32'(err_pulse), 32'd0);
        good_desc(); dst_size = 3'd3; dst_off_lo = 3'd0; dst_addr_lo = 3'd4;
        pulse(6, 1, 0, 0, 0, 0, 0, 0);
        check("R9 R2 destination replaces entry", err_status, stat(6, 9'h020));
        good_desc(); src_size = 3'd5; src_off_lo = 3'd3;
        pulse(1, 1, 0, 0, 0, 0, 0, 0);
        check("R3 bad source size code", err_status, stat(1, 9'h080));
        good_desc(); dst_size = 3'd7; dst_addr_lo = 3'd0; dst_off_lo = 3'd1;
        pulse(2, 1, 0, 0, 0, 0, 0, 0);
        check("R3 bad destination size code", err_status, stat(2, 9'h020));
    endtask

    task automatic t_offset_iter();
        good_desc(); src_off_lo = 3'b110;  // -2 with 4-byte size
        pulse(2, 1, 0, 0, 0, 0, 0, 0);
        check("R4 negative source offset", err_status, stat(2, 9'h040));
        good_desc(); dst_size = 3'd1; dst_off_lo = 3'd3;
        pulse(3, 1, 0, 0, 0, 0, 0, 0);
        check("R4 destination offset", err_status, stat(3, 9'h010));
        good_desc(); dst_size = 3'd1; dst_off_lo = 3'd6;
        pulse(4, 1, 0, 0, 0, 0, 0, 0);
        check("R9 R4 even offset accepted, log kept", err_status, stat(3, 9'h010));
        good_desc(); minor_bytes = 30'd0;
        pulse(7, 1, 0, 0, 0, 0, 0, 0);
        check("R5 zero minor count", err_status, stat(7, 9'h008));
        good_desc(); cur_iter = 15'd9;
        pulse(8, 1, 0, 0, 0, 0, 0, 0);
        check("R5 iteration mismatch", err_status, stat(8, 9'h008));
        good_desc(); src_addr_lo = 3'd1; minor_bytes = 30'd0;
        pulse(9, 1, 0, 0, 0, 0, 0, 0);
        check("R14 merged descriptor faults", err_status, stat(9, 9'h088));
    endtask

    task automatic t_sg_bus();
        good_desc();
        sg_enable = 1'b0; sg_addr_lo = 5'h10;
        pulse(10, 0, 1, 0, 0, 0, 0, 0);
        check("R6 chaining off not checked", err_status, stat(9, 9'h088));
        sg_enable = 1'b1; sg_addr_lo = 5'h00;
        pulse(11, 0, 1, 0, 0, 0, 0, 0);
        check("R6 aligned next address", err_status, stat(9, 9'h088));
        sg_addr_lo = 5'h10;
        pulse(12, 0, 1, 0, 0, 0, 0, 0);
        check("R6 misaligned next address", err_status, stat(12, 9'h004));
        sg_enable = 1'b0;
        pulse(13, 0, 0, 1, 0, 0, 0, 0);
        check("R7 read bus error", err_status, stat(13, 9'h002));
        pulse(14, 0, 0, 0, 1, 0, 0, 0);
        check("R7 write bus error", err_status, stat(14, 9'h001));
        pulse(63, 0, 0, 0, 0, 1, 0, 0);
        check("R7 R8 cancel with top channel", err_status, stat(63, 9'h100));
        pulse(15, 0, 0, 1, 1, 0, 0, 0);
        check("R14 both bus errors", err_status, stat(15, 9'h003));
    endtask

    task automatic t_clear();
        pulse(0, 0, 0, 0, 0, 0, 1, 0);
        check("R13 clear empties log", err_status, 32'd0);
        check("R13 valid low", 32'(err_valid), 32'd0);
        pulse(20, 0, 0, 0, 1, 0, 1, 0);
        check("R13 event wins over clear", err_status, stat(20, 9'h001));
    endtask

    task automatic t_halt();
        halt_on_err = 1'b0;
        pulse(21, 0, 0, 1, 0, 0, 0, 0);
        check("R11 no halt without policy", 32'(halt_req), 32'd0);
        halt_on_err = 1'b1;
        pulse(22, 0, 0, 0, 0, 1, 0, 0);
        check("R11 halt set by error", 32'(halt_req), 32'd1);
        pulse(0, 0, 0, 0, 0, 0, 1, 0);
        check("R13 clear keeps halt", 32'(halt_req), 32'd1);
        check("R13 clear while halted", err_status, 32'd0);
        good_desc(); src_addr_lo = 3'd3;
        pulse(23, 1, 0, 0, 0, 0, 0, 0);
        check("R12 start ignored while halted", err_status, 32'd0);
        check("R12 no pulse while halted", 32'(err_pulse), 32'd0);
        pulse(24, 0, 0, 0, 1, 0, 0, 0);
        check("R12 bus error still logged", err_status, stat(24, 9'h001));
        pulse(0, 0, 0, 0, 0, 0, 0, 1);
        check("R11 halt released", 32'(halt_req), 32'd0);
        pulse(25, 1, 0, 0, 0, 0, 0, 0);
        check("R12 start logged after release", err_status, stat(25, 9'h080));
        check("R11 halt set again", 32'(halt_req), 32'd1);
        halt_on_err = 1'b0;
        pulse(0, 0, 0, 0, 0, 0, 0, 1);
        check("R11 final release", 32'(halt_req), 32'd0);
    endtask

    initial begin
        rst = 1'b1; chk_start = 0; ev_chan = 0; major_done = 0; sg_enable = 0;
        sg_addr_lo = 0; rd_bus_err = 0; wr_bus_err = 0; xfer_cancel = 0;
        halt_on_err = 0; halt_clr = 0; log_clr = 0;
        good_desc();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_addr();
        t_offset_iter();
        t_sg_bus();
        t_clear();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule